// File: doc/BRIEF.md
# Dual-Port Bridge Interrupt Status Word

This block gathers the interrupt and error sources of a bridge between a host bus and a peripheral bus into one 32-bit status word. The word can be read from two bus ports, one on the host side and one on the peripheral side. It also drives a single combined interrupt line.

The low byte holds two kinds of bits. Bits 7 to 4 are live levels, re-sampled every cycle: the OR of each doorbell register and the two DMA-completion flags. Bits 3 to 0 are sticky error flags. Each is set by one or more single-cycle event pulses and stays set until the host-side port writes a 1 to it. The peripheral-side port can only read. The doorbell registers, the DMA engines, bus decoding and the timeout counters all sit outside the block. The block sees only their levels and pulses.

Both read ports are driven straight from flops, so an input is visible on the read ports one cycle after it is presented. The interrupt output is one cycle later again.

Top module: `bridge_irq_status`

## Requirements
- R1: Bits 31 to 8 of the word always read as zero on both read ports, whatever is written.
- R2: While synchronous reset is high, the whole word and the interrupt output are zero at the next clock edge.
- R3: Bit 7 equals the OR of all peripheral-side doorbell bits, and bit 6 equals the OR of all host-side doorbell bits. Both are sampled one cycle earlier.
- R4: Bit 5 equals the peripheral-to-host DMA done flag, and bit 4 equals the host-to-peripheral DMA done flag. Both are sampled one cycle earlier.
- R5: A host-bus error-response pulse sets bit 3, and bit 3 stays set until it is cleared.
- R6: Any of the three parity pulses (master read parity, parity error signalled by the target on a master write, target write parity) sets bit 2.
- R7: Any of the four fatal pulses (master abort, target abort, ready timeout, retry timeout) sets bit 1.
- R8: A system-error pulse sets bit 0.
- R9: A host-side write clears, at the next edge, each of bits 3 to 0 that is written as 1. A bit written as 0 is unchanged.
- R10: When a set pulse and a host clear hit the same sticky bit in the same cycle, the bit ends up set.
- R11: Host writes to bits 31 to 4 have no effect. Any peripheral-side write has no effect.
- R12: Both read ports present the same value in every cycle.
- R13: The interrupt output equals the OR of bits 7 to 0 as they were one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| periph_dbell | input | DBELL_W | Contents of the peripheral-side doorbell register |
| host_dbell | input | DBELL_W | Contents of the host-side doorbell register |
| p2h_dma_done | input | 1 | Peripheral-to-host DMA complete level |
| h2p_dma_done | input | 1 | Host-to-peripheral DMA complete level |
| host_err_resp | input | 1 | Pulse: host master got an ERROR response |
| par_mst_rd | input | 1 | Pulse: parity error on a master read |
| par_mst_wr_tgt | input | 1 | Pulse: target signalled parity error on a master write |
| par_tgt_wr | input | 1 | Pulse: parity error on a target write |
| fat_mst_abort | input | 1 | Pulse: master abort |
| fat_tgt_abort | input | 1 | Pulse: target abort |
| fat_rdy_tmo | input | 1 | Pulse: target claimed the cycle but never became ready |
| fat_retry_tmo | input | 1 | Pulse: retry count exceeded its limit |
| sys_err | input | 1 | Pulse: system-error signal seen asserted |
| h_wr_en | input | 1 | Host-side write strobe |
| h_wr_data | input | WORD_W | Host-side write data |
| h_rd_data | output | WORD_W | Host-side read data |
| p_wr_en | input | 1 | Peripheral-side write strobe (ignored) |
| p_wr_data | input | WORD_W | Peripheral-side write data (ignored) |
| p_rd_data | output | WORD_W | Peripheral-side read data |
| irq_out | output | 1 | Combined interrupt, registered |

## Verification
A sticky flop that drops or misses an event shows up at both read ports one cycle after the pulse or write. It stays wrong for as long as the error source is quiet, so a lost set and a stray clear are both visible in the next cycle. A wrong live bit appears one cycle after its doorbell or DMA level changes. Any state error then reaches the interrupt output one cycle later again. The checks therefore compare the whole word and the interrupt line every cycle against a model, rather than only at chosen points.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  // sticky bit positions in the status byte
  localparam int SERR_BIT    = 0;
  localparam int FATAL_BIT   = 1;
  localparam int PARITY_BIT  = 2;
  localparam int HOSTERR_BIT = 3;
  // live bit positions
  localparam int H2P_BIT     = 4;
  localparam int P2H_BIT     = 5;
  localparam int HDB_BIT     = 6;
  localparam int PDB_BIT     = 7;

  localparam int STICKY_N    = 4;
  localparam int LIVE_N      = 4;
  localparam int USED_W      = STICKY_N + LIVE_N;
  localparam int MAX_SRC     = 4;

  typedef logic [MAX_SRC-1:0] src_vec_t;
endpackage

// File: rtl/bsr_live_capture.sv
module bsr_live_capture #(
  parameter int DBELL_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DBELL_W-1:0] periph_dbell,
  input  logic [DBELL_W-1:0] host_dbell,
  input  logic               p2h_dma_done,
  input  logic               h2p_dma_done,
  output logic [3:0]         live_q
);
  logic [3:0] live_d;

  always_comb begin
    live_d[0] = h2p_dma_done;
    live_d[1] = p2h_dma_done;
    live_d[2] = |host_dbell;
    live_d[3] = |periph_dbell;
  end

  always_ff @(posedge clk) begin
    if (rst) live_q <= '0;
    else     live_q <= live_d;
  end
endmodule

// File: rtl/bsr_sticky_bit.sv
module bsr_sticky_bit #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] ev,
  input  logic            clr,
  output logic            q
);
  logic hit;
  assign hit = |ev;

  // a set in the same cycle as a clear wins
  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (hit) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/bsr_irq_reg.sv
module bsr_irq_reg #(
  parameter int SRC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_W-1:0] src,
  output logic             irq_q
);
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |src;
  end
endmodule

// File: rtl/bridge_irq_status.sv
module bridge_irq_status
  import bsr_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int DBELL_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DBELL_W-1:0] periph_dbell,
  input  logic [DBELL_W-1:0] host_dbell,
  input  logic               p2h_dma_done,
  input  logic               h2p_dma_done,
  input  logic               host_err_resp,
  input  logic               par_mst_rd,
  input  logic               par_mst_wr_tgt,
  input  logic               par_tgt_wr,
  input  logic               fat_mst_abort,
  input  logic               fat_tgt_abort,
  input  logic               fat_rdy_tmo,
  input  logic               fat_retry_tmo,
  input  logic               sys_err,
  input  logic               h_wr_en,
  input  logic [WORD_W-1:0]  h_wr_data,
  output logic [WORD_W-1:0]  h_rd_data,
  input  logic               p_wr_en,
  input  logic [WORD_W-1:0]  p_wr_data,
  output logic [WORD_W-1:0]  p_rd_data,
  output logic               irq_out
);
  localparam int RSV_W = WORD_W - USED_W;

  logic [LIVE_N-1:0]   live_q;
  logic [STICKY_N-1:0] sticky_q;
  logic [STICKY_N-1:0] clr_mask;
  src_vec_t            ev_mat [STICKY_N];
  logic [USED_W-1:0]   status_byte;

  // event sources per sticky bit, unused slots tied low
  always_comb begin
    ev_mat[SERR_BIT]    = {3'b000, sys_err};
    ev_mat[FATAL_BIT]   = {fat_retry_tmo, fat_rdy_tmo, fat_tgt_abort, fat_mst_abort};
    ev_mat[PARITY_BIT]  = {1'b0, par_tgt_wr, par_mst_wr_tgt, par_mst_rd};
    ev_mat[HOSTERR_BIT] = {3'b000, host_err_resp};
  end

  // only the host port clears, and only the sticky bits
  assign clr_mask = h_wr_en ? h_wr_data[STICKY_N-1:0] : '0;

  bsr_live_capture #(.DBELL_W(DBELL_W)) live_i (
    .clk          (clk),
    .rst          (rst),
    .periph_dbell (periph_dbell),
    .host_dbell   (host_dbell),
    .p2h_dma_done (p2h_dma_done),
    .h2p_dma_done (h2p_dma_done),
    .live_q       (live_q)
  );

  for (genvar i = 0; i < STICKY_N; i++) begin : g_sticky
    bsr_sticky_bit #(.NSRC(MAX_SRC)) bit_i (
      .clk (clk),
      .rst (rst),
      .ev  (ev_mat[i]),
      .clr (clr_mask[i]),
      .q   (sticky_q[i])
    );
  end

  assign status_byte = {live_q, sticky_q};
  assign h_rd_data   = {{RSV_W{1'b0}}, status_byte};
  assign p_rd_data   = {{RSV_W{1'b0}}, status_byte};

  bsr_irq_reg #(.SRC_W(USED_W)) irq_i (
    .clk   (clk),
    .rst   (rst),
    .src   (status_byte),
    .irq_q (irq_out)
  );
endmodule

// File: rtl/bridge_irq_status_chk.sv
module bridge_irq_status_chk #(
  parameter int WORD_W  = 32,
  parameter int DBELL_W = 32
) (
  input logic               clk,
  input logic               rst,
  input logic [DBELL_W-1:0] periph_dbell,
  input logic [DBELL_W-1:0] host_dbell,
  input logic               host_err_resp,
  input logic               par_mst_rd,
  input logic               h_wr_en,
  input logic [WORD_W-1:0]  h_wr_data,
  input logic [WORD_W-1:0]  h_rd_data,
  input logic               p_wr_en,
  input logic [WORD_W-1:0]  p_wr_data,
  input logic [WORD_W-1:0]  p_rd_data,
  input logic               irq_out
);
  // R1
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (h_rd_data[WORD_W-1:8] == '0) && (p_rd_data[WORD_W-1:8] == '0));

  // R12
  ports_agree_chk: assert property (@(posedge clk) disable iff (rst)
    h_rd_data == p_rd_data);

  // R3
  dbell_live_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (h_rd_data[7] == $past(|periph_dbell)) && (h_rd_data[6] == $past(|host_dbell)));

  // R5
  hosterr_set_chk: assert property (@(posedge clk) disable iff (rst)
    host_err_resp |=> h_rd_data[3]);

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (par_mst_rd && h_wr_en && h_wr_data[2]) |=> h_rd_data[2]);

  // R11
  periph_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (p_wr_en && !h_wr_en && (p_wr_data != '0)) |=>
      ((~h_rd_data[3:0] & $past(h_rd_data[3:0])) == 4'b0000));

  // R11
  upper_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (h_wr_en && (h_wr_data[WORD_W-1:4] != '0) && (h_wr_data[3:0] == 4'b0000)) |=>
      ((~h_rd_data[3:0] & $past(h_rd_data[3:0])) == 4'b0000));

  // R13
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq_out == $past(|h_rd_data[7:0]));
endmodule

bind bridge_irq_status bridge_irq_status_chk #(.WORD_W(WORD_W), .DBELL_W(DBELL_W)) chk_i (.*);

// File: tb/bridge_irq_status_tb_top.sv
`timescale 1ns/1ps
module bridge_irq_status_tb_top;
  localparam int WW = 32;
  localparam int DW = 32;

  typedef struct {
    logic [WW-1:0] word;
    logic          irq;
    string         tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DW-1:0] periph_dbell = '0, host_dbell = '0;
  logic p2h_dma_done = 0, h2p_dma_done = 0, host_err_resp = 0;
  logic par_mst_rd = 0, par_mst_wr_tgt = 0, par_tgt_wr = 0;
  logic fat_mst_abort = 0, fat_tgt_abort = 0, fat_rdy_tmo = 0, fat_retry_tmo = 0;
  logic sys_err = 0, h_wr_en = 0, p_wr_en = 0;
  logic [WW-1:0] h_wr_data = '0, p_wr_data = '0;
  logic [WW-1:0] h_rd_data, p_rd_data;
  logic irq_out;

  exp_t  sb_q[$];
  logic [WW-1:0] m_word = '0;
  logic  m_irq = 1'b0;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  bridge_irq_status #(.WORD_W(WW), .DBELL_W(DW)) dut_i (.*);

  // driver: model the next state from the applied inputs and queue it
  task automatic step(string tag);
    logic [WW-1:0] nw;
    logic          ni;
    logic [3:0]    setv, clrv;
    nw = '0;
    ni = 1'b0;
    if (!rst) begin
      setv = {host_err_resp, par_mst_rd | par_mst_wr_tgt | par_tgt_wr,
              fat_mst_abort | fat_tgt_abort | fat_rdy_tmo | fat_retry_tmo, sys_err};
      clrv = h_wr_en ? h_wr_data[3:0] : 4'b0000;
      nw[3:0] = setv | (m_word[3:0] & ~clrv);
      nw[7:4] = {|periph_dbell, |host_dbell, p2h_dma_done, h2p_dma_done};
      ni = |m_word[7:0];
    end
    m_word = nw;
    m_irq  = ni;
    sb_q.push_back('{word: nw, irq: ni, tag: tag});
    @(negedge clk);
    host_err_resp = 0; par_mst_rd = 0; par_mst_wr_tgt = 0; par_tgt_wr = 0;
    fat_mst_abort = 0; fat_tgt_abort = 0; fat_rdy_tmo = 0; fat_retry_tmo = 0;
    sys_err = 0; h_wr_en = 0; h_wr_data = '0; p_wr_en = 0; p_wr_data = '0;
  endtask

  task automatic hclear(logic [WW-1:0] d, string tag);
    h_wr_en = 1; h_wr_data = d;
    step(tag);
  endtask

  // monitor: compare after each edge
  always @(posedge clk) begin
    #2;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (h_rd_data !== e.word) begin
        fails++;
        $display("FAIL %s host word actual=%h expected=%h", e.tag, h_rd_data, e.word);
      end
      checks++;
      if (p_rd_data !== e.word) begin
        fails++;
        $display("FAIL R12 periph word actual=%h expected=%h", p_rd_data, e.word);
      end
      checks++;
      if (irq_out !== e.irq) begin
        fails++;
        $display("FAIL R13 irq actual=%b expected=%b", irq_out, e.irq);
      end
    end
  end

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    fails++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    @(negedge clk);
    // R2: reset, with inputs active
    host_err_resp = 1; periph_dbell = 32'h1;
    step("R2");
    step("R2");
    rst = 0; periph_dbell = '0;
    step("R2");
    // R3 doorbells, including a high bit
    periph_dbell = 32'h8000_0000;
    step("R3");
    host_dbell = 32'h0000_0100; periph_dbell = '0;
    step("R3");
    host_dbell = '0;
    step("R3");
    // R4 DMA levels
    p2h_dma_done = 1;
    step("R4");
    p2h_dma_done = 0; h2p_dma_done = 1;
    step("R4");
    h2p_dma_done = 0;
    step("R4");
    // R5 host error, sticky
    host_err_resp = 1;
    step("R5");
    step("R5");
    step("R5");
    // R6 each parity source
    par_mst_rd = 1;     step("R6");
    hclear(32'h4, "R9");
    par_mst_wr_tgt = 1; step("R6");
    hclear(32'h4, "R9");
    par_tgt_wr = 1;     step("R6");
    // R7 each fatal source
    fat_mst_abort = 1;  step("R7");
    hclear(32'h2, "R9");
    fat_tgt_abort = 1;  step("R7");
    hclear(32'h2, "R9");
    fat_rdy_tmo = 1;    step("R7");
    hclear(32'h2, "R9");
    fat_retry_tmo = 1;  step("R7");
    // R8 system error
    sys_err = 1;        step("R8");
    step("R8");
    // R9: zero write keeps all, single-bit write clears only that bit
    hclear(32'h0, "R9");
    hclear(32'h4, "R9");
    // R10: set and clear together
    sys_err = 1; h_wr_en = 1; h_wr_data = 32'h1;
    step("R10");
    host_err_resp = 1; h_wr_en = 1; h_wr_data = 32'hF;
    step("R10");
    // R11 / R1: upper writes with live bits up, periph writes
    host_dbell = 32'h3; p2h_dma_done = 1;
    step("R11");
    hclear(32'hFFFF_FFF0, "R11");
    hclear(32'hFFFF_FF00, "R1");
    p_wr_en = 1; p_wr_data = 32'hFFFF_FFFF;
    step("R11");
    step("R11");
    // clear everything, levels off, irq falls
    host_dbell = '0; p2h_dma_done = 0;
    hclear(32'hF, "R9");
    step("R13");
    step("R13");
    step("R13");
    // mid-run reset with sticky bits set
    fat_tgt_abort = 1; step("R7");
    rst = 1; step("R2");
    rst = 0; step("R2");
    repeat (2) @(negedge clk);
    summary();
  end
endmodule